// File: doc/BRIEF.md
# Dual-Result SAR Converter Readout Controller

This block is the host-side sequencer for an external two-channel successive-approximation converter whose two results share one serial data line. On a start request it pulls the convert-start strobe low, waits for the converter's BUSY line to fall, then lowers chip select and clocks the result in over a divided serial clock. Either one channel's result is read, or both back to back in one continuous transfer. Chip select is raised by the controller itself, because the converter releases the data line only on that rising edge. A quiet interval is then enforced before the next conversion may begin.

A power-down request keeps the convert-start strobe low across the end of conversion. This puts the converter into shutdown, and no read follows. A start request that arrives while the controller is working is held and served once the quiet interval has run out. If BUSY does not fall within a set number of clocks after the strobe falls, an error pulse is raised.

Top module: `sar_pair_reader`

## Requirements
- R1: While reset is held and in the first idle cycle after it, convStN, csN and sclk are 1, and resultValid, timeoutErr, resultA and resultB are 0.
- R2: wideSel, dualSel and pwrDownReq are sampled when a conversion starts. Without power-down, convStN is low for exactly CONV_LOW_CLKS clocks and is back at 1 when busyIn falls.
- R3: With pwrDownReq=1, convStN stays low until the falling edge of busyIn is sampled and rises in the following clock. csN stays 1 and no resultValid pulse is produced.
- R4: In a normal conversion, csN goes low in the clock after the falling edge of busyIn is sampled. No read starts before that.
- R5: sclk is 1 whenever csN is 1. During a read, sclk toggles every SCLK_HALF clocks, and its first transition, a fall, comes SCLK_HALF clocks after csN falls. sdoIn is captured on each falling sclk edge.
- R6: A single read (dualSel=0) gives exactly 12 sclk falls when wideSel=0 and 14 when wideSel=1. The bits, MSB first, go right-justified and zero-extended into resultA. resultB keeps its previous value.
- R7: A dual read (dualSel=1) gives 24 or 28 sclk falls with csN held low throughout. The first half of the bits goes to resultA and the second half to resultB, each MSB first.
- R8: After the last bit, csN rises together with sclk's final rise. resultValid is a one-cycle pulse in that same clock, and the new results are present while it is high.
- R9: At least QUIET_CLKS clocks pass between a rise of csN (or of convStN after a shutdown or timeout) and the next fall of convStN.
- R10: A startReq that arrives while the controller is not idle is held, not lost. Requests that arrive while one is already held merge into it. The held request starts its conversion QUIET_CLKS+1 clocks after csN rises.
- R11: If busyIn has not fallen BUSY_TIMEOUT clocks after convStN fell, timeoutErr pulses for one clock in that cycle and convStN returns to 1. No read follows.
- R12: convStN is never low while csN is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Request one conversion and readout |
| wideSel | input | 1 | 1 selects 14-bit results, 0 selects 12-bit |
| dualSel | input | 1 | 1 reads both channels in one transfer |
| pwrDownReq | input | 1 | 1 makes this conversion put the converter into shutdown |
| busyIn | input | 1 | Converter conversion-in-progress flag |
| sdoIn | input | 1 | Shared serial result line |
| convStN | output | 1 | Active-low convert-start strobe |
| csN | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idles high |
| resultA | output | 14 | First result of the transfer |
| resultB | output | 14 | Second result of a dual transfer |
| resultValid | output | 1 | One-cycle pulse when the results are updated |
| timeoutErr | output | 1 | One-cycle pulse when BUSY fails to fall in time |

## Verification
The end of a read and a new start request can land in the same clock. In that clock csN rises, resultValid pulses and the controller leaves the read state, so the request is at risk of being dropped. The bench watches the falling sclk edges, finds the last one, and times a startReq pulse so that it is sampled on exactly the edge where csN rises. It then expects a second conversion to begin without any further request, exactly QUIET_CLKS+1 clocks later, and checks that both transfers return the channel values its converter model supplied.

// File: rtl/sar_pair_pkg.sv
package sar_pair_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONV,
    ST_WAIT,
    ST_READ,
    ST_QUIET
  } ctlState_t;

  // strobes from the sequencer to the capture datapath
  typedef struct packed {
    logic clear;
    logic shift;
    logic load;
    logic wide;
    logic dual;
  } dpCtl_t;

endpackage

// File: rtl/sar_pair_ctrl.sv
module sar_pair_ctrl
  import sar_pair_pkg::*;
#(
  parameter int NARROW_BITS   = 12,
  parameter int WIDE_BITS     = 14,
  parameter int SCLK_HALF     = 2,
  parameter int CONV_LOW_CLKS = 2,
  parameter int QUIET_CLKS    = 8,
  parameter int BUSY_TIMEOUT  = 100
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   startReq,
  input  logic   wideSel,
  input  logic   dualSel,
  input  logic   pwrDownReq,
  input  logic   busyIn,
  output logic   convStN,
  output logic   csN,
  output logic   sclk,
  output logic   timeoutErr,
  output dpCtl_t dpCtl
);

  localparam int HALF_W  = $clog2(SCLK_HALF + 1);
  localparam int LOW_W   = $clog2(CONV_LOW_CLKS + 1);
  localparam int QUIET_W = $clog2(QUIET_CLKS + 1);
  localparam int TMO_W   = $clog2(BUSY_TIMEOUT + 1);
  localparam int BIT_W   = $clog2(2 * WIDE_BITS + 1);

  ctlState_t          state;
  logic               pending;
  logic               wideLat;
  logic               dualLat;
  logic               pdLat;
  logic               busyPrev;
  logic [LOW_W-1:0]   lowCnt;
  logic [TMO_W-1:0]   tmoCnt;
  logic [QUIET_W-1:0] quietCnt;
  logic [HALF_W-1:0]  halfCnt;
  logic [BIT_W-1:0]   bitCnt;

  logic               busyFall;
  logic               halfDone;
  logic               startNow;
  logic [BIT_W-1:0]   laneBits;
  logic [BIT_W-1:0]   totalBits;

  always_comb begin
    busyFall  = busyPrev & ~busyIn;
    halfDone  = (halfCnt == HALF_W'(SCLK_HALF - 1));
    startNow  = (state == ST_IDLE) && (startReq || pending);
    laneBits  = wideLat ? BIT_W'(WIDE_BITS) : BIT_W'(NARROW_BITS);
    totalBits = dualLat ? (laneBits << 1) : laneBits;

    dpCtl.clear = startNow;
    dpCtl.shift = (state == ST_READ) && halfDone && sclk;
    dpCtl.load  = (state == ST_READ) && halfDone && !sclk && (bitCnt == totalBits);
    dpCtl.wide  = wideLat;
    dpCtl.dual  = dualLat;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      pending    <= 1'b0;
      wideLat    <= 1'b0;
      dualLat    <= 1'b0;
      pdLat      <= 1'b0;
      busyPrev   <= 1'b0;
      lowCnt     <= '0;
      tmoCnt     <= '0;
      quietCnt   <= '0;
      halfCnt    <= '0;
      bitCnt     <= '0;
      convStN    <= 1'b1;
      csN        <= 1'b1;
      sclk       <= 1'b1;
      timeoutErr <= 1'b0;
    end else begin
      busyPrev   <= busyIn;
      timeoutErr <= 1'b0;

      if (startNow) begin
        pending <= 1'b0;
      end else if (startReq) begin
        pending <= 1'b1;
      end

      case (state)
        ST_IDLE: begin
          if (startNow) begin
            wideLat <= wideSel;
            dualLat <= dualSel;
            pdLat   <= pwrDownReq;
            convStN <= 1'b0;
            lowCnt  <= '0;
            tmoCnt  <= '0;
            state   <= ST_CONV;
          end
        end

        ST_CONV: begin
          tmoCnt <= tmoCnt + 1'b1;
          if (lowCnt == LOW_W'(CONV_LOW_CLKS - 1)) begin
            // a shutdown keeps the strobe low across the end of conversion
            if (!pdLat) begin
              convStN <= 1'b1;
            end
            state <= ST_WAIT;
          end else begin
            lowCnt <= lowCnt + 1'b1;
          end
        end

        ST_WAIT: begin
          tmoCnt <= tmoCnt + 1'b1;
          if (busyFall) begin
            convStN <= 1'b1;
            if (pdLat) begin
              quietCnt <= '0;
              state    <= ST_QUIET;
            end else begin
              csN     <= 1'b0;
              halfCnt <= '0;
              bitCnt  <= '0;
              state   <= ST_READ;
            end
          end else if (tmoCnt == TMO_W'(BUSY_TIMEOUT - 1)) begin
            timeoutErr <= 1'b1;
            convStN    <= 1'b1;
            quietCnt   <= '0;
            state      <= ST_QUIET;
          end
        end

        ST_READ: begin
          if (halfDone) begin
            halfCnt <= '0;
            sclk    <= ~sclk;
            if (sclk) begin
              bitCnt <= bitCnt + 1'b1;
            end else if (bitCnt == totalBits) begin
              // the line is only released by chip select, so end it here
              csN      <= 1'b1;
              quietCnt <= '0;
              state    <= ST_QUIET;
            end
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end

        ST_QUIET: begin
          if (quietCnt == QUIET_W'(QUIET_CLKS - 1)) begin
            state <= ST_IDLE;
          end else begin
            quietCnt <= quietCnt + 1'b1;
          end
        end

        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sar_pair_dp.sv
module sar_pair_dp
  import sar_pair_pkg::*;
#(
  parameter int NARROW_BITS = 12,
  parameter int WIDE_BITS   = 14
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sdoIn,
  input  dpCtl_t               dpCtl,
  output logic [WIDE_BITS-1:0] resultA,
  output logic [WIDE_BITS-1:0] resultB,
  output logic                 resultValid
);

  localparam int SR_W = 2 * WIDE_BITS;

  logic [SR_W-1:0]      shiftReg;
  logic [SR_W-1:0]      laneMask;
  logic [SR_W-1:0]      hiLane;
  logic [SR_W-1:0]      loLane;
  logic [WIDE_BITS-1:0] nextA;
  logic [WIDE_BITS-1:0] nextB;
  int                   laneW;

  // the last-captured bit sits at bit 0; split by the latched lane width
  always_comb begin
    laneW    = dpCtl.wide ? WIDE_BITS : NARROW_BITS;
    laneMask = {SR_W{1'b1}} >> (SR_W - laneW);
    hiLane   = (shiftReg >> laneW) & laneMask;
    loLane   = shiftReg & laneMask;
    nextA    = dpCtl.dual ? hiLane[WIDE_BITS-1:0] : loLane[WIDE_BITS-1:0];
    nextB    = loLane[WIDE_BITS-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg    <= '0;
      resultA     <= '0;
      resultB     <= '0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= 1'b0;
      if (dpCtl.clear) begin
        shiftReg <= '0;
      end else if (dpCtl.shift) begin
        shiftReg <= {shiftReg[SR_W-2:0], sdoIn};
      end
      if (dpCtl.load) begin
        resultA     <= nextA;
        resultValid <= 1'b1;
        if (dpCtl.dual) begin
          resultB <= nextB;
        end
      end
    end
  end

endmodule

// File: rtl/sar_pair_reader.sv
module sar_pair_reader
  import sar_pair_pkg::*;
#(
  parameter int NARROW_BITS   = 12,
  parameter int WIDE_BITS     = 14,
  parameter int SCLK_HALF     = 2,
  parameter int CONV_LOW_CLKS = 2,
  parameter int QUIET_CLKS    = 8,
  parameter int BUSY_TIMEOUT  = 100
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startReq,
  input  logic                 wideSel,
  input  logic                 dualSel,
  input  logic                 pwrDownReq,
  input  logic                 busyIn,
  input  logic                 sdoIn,
  output logic                 convStN,
  output logic                 csN,
  output logic                 sclk,
  output logic [WIDE_BITS-1:0] resultA,
  output logic [WIDE_BITS-1:0] resultB,
  output logic                 resultValid,
  output logic                 timeoutErr
);

  dpCtl_t dpCtl;

  sar_pair_ctrl #(
    .NARROW_BITS  (NARROW_BITS),
    .WIDE_BITS    (WIDE_BITS),
    .SCLK_HALF    (SCLK_HALF),
    .CONV_LOW_CLKS(CONV_LOW_CLKS),
    .QUIET_CLKS   (QUIET_CLKS),
    .BUSY_TIMEOUT (BUSY_TIMEOUT)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .wideSel   (wideSel),
    .dualSel   (dualSel),
    .pwrDownReq(pwrDownReq),
    .busyIn    (busyIn),
    .convStN   (convStN),
    .csN       (csN),
    .sclk      (sclk),
    .timeoutErr(timeoutErr),
    .dpCtl     (dpCtl)
  );

  sar_pair_dp #(
    .NARROW_BITS(NARROW_BITS),
    .WIDE_BITS  (WIDE_BITS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .sdoIn      (sdoIn),
    .dpCtl      (dpCtl),
    .resultA    (resultA),
    .resultB    (resultB),
    .resultValid(resultValid)
  );

endmodule

// File: rtl/sar_pair_checker.sv
module sar_pair_checker #(
  parameter int NARROW_BITS = 12,
  parameter int WIDE_BITS   = 14,
  parameter int QUIET_CLKS  = 8
) (
  input logic clk,
  input logic rstN,
  input logic wideSel,
  input logic dualSel,
  input logic convStN,
  input logic csN,
  input logic sclk,
  input logic resultValid,
  input logic timeoutErr
);

  localparam int BIT_W = $clog2(2 * WIDE_BITS + 1);
  localparam int GAP_W = $clog2(QUIET_CLKS + 2) + 1;
  localparam logic [GAP_W-1:0] GAP_MAX = {GAP_W{1'b1}};

  logic             csPrev;
  logic             sclkPrev;
  logic             convPrev;
  logic [BIT_W-1:0] fallCnt;
  logic [BIT_W-1:0] expBits;
  logic [GAP_W-1:0] gapCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev   <= 1'b1;
      sclkPrev <= 1'b1;
      convPrev <= 1'b1;
      fallCnt  <= '0;
      expBits  <= '0;
      gapCnt   <= GAP_MAX;
    end else begin
      csPrev   <= csN;
      sclkPrev <= sclk;
      convPrev <= convStN;
      if (csN && csPrev) begin
        fallCnt <= '0;
      end else if (sclkPrev && !sclk) begin
        fallCnt <= fallCnt + 1'b1;
      end
      if (convPrev && !convStN) begin
        expBits <= (wideSel ? BIT_W'(WIDE_BITS) : BIT_W'(NARROW_BITS)) << dualSel;
      end
      if (!csPrev && csN) begin
        gapCnt <= '0;
      end else if (gapCnt != GAP_MAX) begin
        gapCnt <= gapCnt + 1'b1;
      end
    end
  end

  assert_sclk_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> sclk);

  // R6 and R7: the number of falling edges in one select window
  assert_bit_count_R6_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> (fallCnt == expBits));

  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  assert_valid_at_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> ($rose(csN) && sclk));

  assert_quiet_gap_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(convStN) |-> (gapCnt >= GAP_W'(QUIET_CLKS)));

  assert_timeout_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |-> (csN && convStN) ##1 !timeoutErr);

  assert_no_overlap_R12: assert property (@(posedge clk) disable iff (!rstN)
    !convStN |-> csN);

endmodule

bind sar_pair_reader sar_pair_checker #(
  .NARROW_BITS(NARROW_BITS),
  .WIDE_BITS  (WIDE_BITS),
  .QUIET_CLKS (QUIET_CLKS)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wideSel    (wideSel),
  .dualSel    (dualSel),
  .convStN    (convStN),
  .csN        (csN),
  .sclk       (sclk),
  .resultValid(resultValid),
  .timeoutErr (timeoutErr)
);

// File: tb/sim_sar_pair_reader.sv
module sim_sar_pair_reader;

  localparam int NARROW = 12;
  localparam int WIDE   = 14;
  localparam int HALF   = 2;
  localparam int LOWCLK = 2;
  localparam int QUIET  = 8;
  localparam int TMO    = 100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic wideSel = 1'b0;
  logic dualSel = 1'b0;
  logic pwrDownReq = 1'b0;
  logic busyIn = 1'b0;
  logic sdoIn = 1'b0;
  logic convStN, csN, sclk, resultValid, timeoutErr;
  logic [WIDE-1:0] resultA, resultB;

  always #4 clk = ~clk;

  sar_pair_reader #(
    .NARROW_BITS(NARROW), .WIDE_BITS(WIDE), .SCLK_HALF(HALF),
    .CONV_LOW_CLKS(LOWCLK), .QUIET_CLKS(QUIET), .BUSY_TIMEOUT(TMO)
  ) u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .wideSel(wideSel),
    .dualSel(dualSel), .pwrDownReq(pwrDownReq), .busyIn(busyIn), .sdoIn(sdoIn),
    .convStN(convStN), .csN(csN), .sclk(sclk), .resultA(resultA),
    .resultB(resultB), .resultValid(resultValid), .timeoutErr(timeoutErr)
  );

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int laneBits(input bit w);
    return w ? WIDE : NARROW;
  endfunction

  function automatic int totalBits(input bit w, input bit d);
    return laneBits(w) * (d ? 2 : 1);
  endfunction

  function automatic logic [WIDE-1:0] lane(input logic [WIDE-1:0] v, input bit w);
    return w ? v : (v & 14'h0FFF);
  endfunction

  // converter model
  bit curWide, curDual, noBusy;
  logic [WIDE-1:0] curA, curB;
  int convClks = 6;
  int bitIdx = 0;

  function automatic logic wordBit(input int i);
    logic [2*WIDE-1:0] word;
    int total;
    total = totalBits(curWide, curDual);
    if (i >= total) return 1'b0;
    if (curDual) word = (28'(lane(curA, curWide)) << laneBits(curWide)) | 28'(lane(curB, curWide));
    else word = 28'(lane(curA, curWide));
    return word[total-1-i];
  endfunction

  always @(negedge csN) begin
    bitIdx = 0;
    sdoIn = wordBit(0);
  end

  always @(posedge sclk) begin
    if (csN === 1'b0) begin
      bitIdx++;
      sdoIn = wordBit(bitIdx);
    end
  end

  initial begin
    forever begin
      @(negedge convStN);
      if (!noBusy) begin
        @(posedge clk); #2 busyIn = 1'b1;
        repeat (convClks) @(posedge clk);
        #2 busyIn = 1'b0;
      end
    end
  end

  // port monitor, sampled on the falling clock edge
  int cyc = 0;
  logic prevCs = 1, prevSclk = 1, prevConv = 1, prevBusy = 0;
  int csFallCyc, csRiseCyc = -1000, convFallCyc, convRiseCyc, busyFallCyc, tmoCyc;
  int fallCnt, bitsRead, firstFallDelay, convLowWidth, gapAtFall;
  int csLowCount = 0, validCount = 0, tmoCount = 0, busyFallCount = 0, convCount = 0;
  logic convAtBusyFall;

  always @(negedge clk) begin
    cyc++;
    if (prevCs && !csN) begin csFallCyc = cyc; fallCnt = 0; csLowCount++; end
    if (!csN && prevSclk && !sclk) begin
      fallCnt++;
      if (fallCnt == 1) firstFallDelay = cyc - csFallCyc;
    end
    if (!prevCs && csN) begin bitsRead = fallCnt; csRiseCyc = cyc; end
    if (prevConv && !convStN) begin convFallCyc = cyc; gapAtFall = cyc - csRiseCyc; convCount++; end
    if (!prevConv && convStN) begin convRiseCyc = cyc; convLowWidth = cyc - convFallCyc; end
    if (prevBusy && !busyIn) begin busyFallCyc = cyc; convAtBusyFall = convStN; busyFallCount++; end
    if (resultValid) validCount++;
    if (timeoutErr) begin tmoCount++; tmoCyc = cyc; end
    prevCs = csN; prevSclk = sclk; prevConv = convStN; prevBusy = busyIn;
  end

  logic [WIDE-1:0] expA = '0, expB = '0;

  task automatic pulseStart();
    @(posedge clk); #2 startReq = 1'b1;
    @(posedge clk); #2 startReq = 1'b0;
  endtask

  task automatic waitValid(input int v0);
    int n = 0;
    while (validCount == v0 && n < 3000) begin @(negedge clk); #1; n++; end
  endtask

  task automatic checkRead(input bit w, input bit d);
    chk(resultValid === 1'b1 && csN === 1'b1 && sclk === 1'b1, "R8 valid with csN rise", int'(csN), 1);
    chk(resultA === expA, "R6 resultA", int'(resultA), int'(expA));
    chk(resultB === expB, d ? "R7 resultB" : "R6 resultB kept", int'(resultB), int'(expB));
    chk(bitsRead == totalBits(w, d), d ? "R7 sclk falls" : "R6 sclk falls", bitsRead, totalBits(w, d));
    chk(firstFallDelay == HALF, "R5 first sclk fall", firstFallDelay, HALF);
    chk(csFallCyc - busyFallCyc == 1, "R4 csN after busy fall", csFallCyc - busyFallCyc, 1);
    @(negedge clk); #1;
    chk(resultValid === 1'b0, "R8 valid one cycle", int'(resultValid), 0);
  endtask

  task automatic runConv(input bit w, input bit d, input bit pd,
                         input logic [WIDE-1:0] a, input logic [WIDE-1:0] b);
    int v0, c0, bf0, n;
    curWide = w; curDual = d; curA = a; curB = b;
    wideSel = w; dualSel = d; pwrDownReq = pd;
    v0 = validCount; c0 = csLowCount; bf0 = busyFallCount;
    pulseStart();
    if (!pd) begin
      expA = lane(a, w);
      if (d) expB = lane(b, w);
      waitValid(v0);
      chk(validCount == v0 + 1, "R8 valid seen", validCount - v0, 1);
      chk(convLowWidth == LOWCLK, "R2 strobe width", convLowWidth, LOWCLK);
      chk(convAtBusyFall === 1'b1, "R2 strobe high at busy fall", int'(convAtBusyFall), 1);
      checkRead(w, d);
    end else begin
      n = 0;
      while (busyFallCount == bf0 && n < 500) begin @(negedge clk); #1; n++; end
      repeat (2) @(negedge clk);
      #1;
      chk(convAtBusyFall === 1'b0, "R3 strobe low at busy fall", int'(convAtBusyFall), 0);
      chk(convRiseCyc - busyFallCyc == 1, "R3 strobe rise", convRiseCyc - busyFallCyc, 1);
      chk(csLowCount == c0, "R3 no select", csLowCount - c0, 0);
      chk(validCount == v0, "R3 no valid", validCount - v0, 0);
    end
    pwrDownReq = 1'b0;
    repeat (QUIET + 4) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    noBusy = 0;
    repeat (4) @(negedge clk);
    #1;
    chk(convStN === 1 && csN === 1 && sclk === 1, "R1 idle lines in reset", int'({convStN, csN, sclk}), 7);
    chk(resultValid === 0 && timeoutErr === 0, "R1 flags in reset", int'({resultValid, timeoutErr}), 0);
    @(posedge clk); #2 rstN = 1'b1;
    @(negedge clk); #1;
    chk(convStN === 1 && csN === 1 && sclk === 1, "R1 idle lines after reset", int'({convStN, csN, sclk}), 7);
    chk(resultA === 0 && resultB === 0, "R1 results after reset", int'(resultA | resultB), 0);

    // directed patterns
    runConv(1, 1, 0, 14'h3FFF, 14'h0000);
    runConv(0, 1, 0, 14'h0800, 14'h0001);
    runConv(1, 0, 0, 14'h2AAA, 14'h1555);
    runConv(0, 0, 0, 14'h3FFF, 14'h0000);
    runConv(0, 0, 1, 14'h0123, 14'h0456);
    runConv(1, 1, 0, 14'h1555, 14'h2AAA);

    // random mix
    for (int i = 0; i < 24; i++) begin
      convClks = 4 + int'($urandom % 16);
      runConv(1'($urandom % 2), 1'($urandom % 2), ($urandom % 6) == 0,
              14'($urandom), 14'($urandom));
    end
    convClks = 6;

    // request lands on the cycle the read completes
    begin
      int v0, cc0;
      curWide = 1; curDual = 1; curA = 14'h1234; curB = 14'h0ABC;
      wideSel = 1; dualSel = 1;
      expA = 14'h1234; expB = 14'h0ABC;
      v0 = validCount; cc0 = convCount;
      pulseStart();
      begin
        int n = 0;
        while (!(csN === 1'b0 && fallCnt == 28) && n < 3000) begin @(negedge clk); #1; n++; end
      end
      repeat (HALF - 1) @(posedge clk);
      #2 startReq = 1'b1;
      @(posedge clk); #2 startReq = 1'b0;
      waitValid(v0);
      checkRead(1, 1);
      curA = 14'h0F0F; curB = 14'h30C3;
      expA = 14'h0F0F; expB = 14'h30C3;
      waitValid(v0 + 1);
      chk(validCount == v0 + 2, "R10 held request served", validCount - v0, 2);
      chk(convCount == cc0 + 2, "R10 one extra conversion", convCount - cc0, 2);
      chk(gapAtFall == QUIET + 1, "R10 restart after quiet", gapAtFall, QUIET + 1);
      chk(gapAtFall >= QUIET, "R9 quiet interval", gapAtFall, QUIET);
      checkRead(1, 1);
      repeat (QUIET + 4) @(negedge clk);
    end

    // converter never signals completion
    begin
      int v0, c0, t0, n;
      noBusy = 1;
      wideSel = 0; dualSel = 0;
      v0 = validCount; c0 = csLowCount; t0 = tmoCount;
      pulseStart();
      n = 0;
      while (tmoCount == t0 && n < TMO + 50) begin @(negedge clk); #1; n++; end
      chk(tmoCount == t0 + 1, "R11 timeout flagged", tmoCount - t0, 1);
      chk(tmoCyc - convFallCyc == TMO, "R11 timeout delay", tmoCyc - convFallCyc, TMO);
      @(negedge clk); #1;
      chk(timeoutErr === 1'b0 && convStN === 1'b1, "R11 pulse and strobe release", int'(timeoutErr), 0);
      repeat (QUIET + 4) @(negedge clk);
      chk(csLowCount == c0 && validCount == v0, "R11 no read after timeout", csLowCount - c0, 0);
      noBusy = 0;
      runConv(1, 0, 0, 14'h2468, 14'h0000);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule